// File: doc/BRIEF.md
# PWM Fault Input Protection

This block watches four external fault pins on behalf of a PWM timer. Each pin is brought into the system clock domain by a two-flop synchronizer. A per-pin polarity bit then selects which level counts as active, and an optional glitch filter sits after that. A rising edge of the conditioned signal sets a sticky per-pin fault flag. The flags are ORed into an aggregate fault flag, and the conditioned levels are ORed into a live fault-level indicator.

While fault handling is on and any flag is set, each channel pair that has its fault override enabled and runs in combine mode drives both of its outputs to programmable safe levels. Pairs without these settings pass the PWM levels through unchanged. An interrupt line follows the aggregate flag, gated by an interrupt enable.

Software reaches the block through a small word-wide register port with four registers: control, input configuration, status and pair configuration. A flag is cleared only by writing 0 to its bit after a status read has returned that bit as 1.

Top module: `pwm_fault_guard`

## Requirements
- R1: A fault pin first passes two synchronizer flops. A pin change driven before clock edge k sets the flag at edge k+2 (bypass path), which shows on `fault_any_o` after edge k+2.
- R2: Input configuration bit 4+n set to 1 makes pin n active-low. Set to 0, pin n is active-high.
- R3: The filter is bypassed when the pin's filter enable (input configuration bit 8+n) is 0, or when the filter length (control bits 7:4) is 0. A single-clock pulse then still sets the flag.
- R4: With the filter in use, a new level reaches the edge detector only after the synchronized level has differed from the filtered level for as many consecutive clocks as the filter length. Any return to the filtered level restarts the count, so shorter pulses are dropped.
- R5: Flag n (status bit n) sets on a rising edge of conditioned input n only when the fault mode (control bits 1:0) is nonzero and the input enable (input configuration bit n) is 1.
- R6: Status bit 4 and `fault_any_o` are the OR of the four flags. Status bit 5 and `fault_level_o` are the OR of the four conditioned levels, registered.
- R7: Writing the status register clears flag n only when data bit n is 0 and a status read since the flag last armed returned bit n as 1. A write of 0 without such a read, or a write of 1, leaves the flag set.
- R8: If a new rising edge on input n lands in the same cycle as a clearing write, flag n stays set.
- R9: Channel pair p (outputs 2p and 2p+1) is forced to safe bits 8+2p and 9+2p of the pair configuration register, one cycle later, when the fault mode is nonzero, some flag is set, pair enable bit p is 1 and combine bit 4+p is 1. Otherwise `ch_o` is `ch_i` delayed by one clock.
- R10: `irq_o` is 1 one clock after both the aggregate flag and the interrupt enable (control bit 2) are 1. It falls once either of them is cleared.
- R11: After reset, all flags, `irq_o`, `ch_o`, `fault_any_o` and `fault_level_o` are 0, and all registers read 0.
- R12: Register reads return data one clock after `reg_rd_i`. The addresses are 0 control, 1 input configuration, 2 status, 3 pair configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_pin_i | input | 4 | Asynchronous fault pins |
| ch_i | input | 8 | PWM channel levels from the timer |
| ch_o | output | 8 | Channel levels after the safe-state override |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, registered |
| fault_any_o | output | 1 | Aggregate fault flag |
| fault_level_o | output | 1 | OR of the conditioned fault levels |
| irq_o | output | 1 | Fault interrupt request |

## Verification
The assertions check these rules on every cycle: the edge detector never produces two rises in a row, the filter holds its output while the input agrees with it, an unarmed flag cannot drop, a set request always leaves the flag set, no flag appears while fault mode is off, the interrupt stays low without its enable, and outputs pass through while no flag is set. Other behaviour only shows up in the bench scenarios. These are the exact synchronizer latency, pulses rejected or accepted at a given filter length, the read-then-write-zero clearing order, the collision between a new edge and a clearing write, and the safe pattern that appears on a given pair.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] ADDR_CTRL   = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_INCFG  = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_STATUS = 2'd2;
  localparam logic [REG_AW-1:0] ADDR_PAIR   = 2'd3;

  typedef struct packed {
    logic [3:0] fval;
    logic       irq_en;
    logic [1:0] mode;
  } ctrl_t;
endpackage

// File: rtl/pfg_input_cond.sv
module pfg_input_cond #(
  parameter int FVAL_W = 4,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_i,
  input  logic              pol_i,
  input  logic              filt_en_i,
  input  logic [FVAL_W-1:0] fval_i,
  output logic              cond_o,
  output logic              rise_o
);
  logic [1:0]       sync_q;
  logic             raw;
  logic             filt_on;
  logic             filt_q;
  logic [CNT_W-1:0] cnt_q;
  logic             prev_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= {2{pol_i}};
    else     sync_q <= {sync_q[0], pin_i};
  end

  assign raw     = sync_q[1] ^ pol_i;
  assign filt_on = filt_en_i && (fval_i != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!filt_on) begin
      filt_q <= raw;
      cnt_q  <= '0;
    end else if (raw == filt_q) begin
      cnt_q  <= '0;
    end else if ((cnt_q + 1'b1) >= CNT_W'(fval_i)) begin
      filt_q <= raw;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign cond_o = filt_on ? filt_q : raw;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= cond_o;
  end

  assign rise_o = cond_o & ~prev_q;

  AST_FILT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (filt_on && raw == filt_q) |=> (filt_q == $past(filt_q))); // R4
  AST_RISE_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o); // R5
endmodule

// File: rtl/pfg_flag_bank.sv
module pfg_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic         rd_hit_i,
  input  logic         wr_hit_i,
  input  logic [N-1:0] wr_bits_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q;
  logic [N-1:0] armed_q;
  logic [N-1:0] clear;
  logic [N-1:0] flags_d;

  assign clear   = {N{wr_hit_i}} & ~wr_bits_i & armed_q;
  assign flags_d = set_i | (flags_q & ~clear);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      armed_q <= '0;
    end else begin
      flags_q <= flags_d;
      armed_q <= flags_d & ~clear & (armed_q | ({N{rd_hit_i}} & flags_q));
    end
  end

  assign flags_o = flags_q;

  for (genvar n = 0; n < N; n++) begin : g_chk
    AST_UNARMED_KEEP: assert property (@(posedge clk) disable iff (rst)
      (flags_q[n] && !armed_q[n]) |=> flags_q[n]); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      set_i[n] |=> flags_q[n]); // R8
  end
endmodule

// File: rtl/pfg_pair_override.sv
module pfg_pair_override #(
  parameter int PAIRS = 4,
  localparam int NCH  = 2 * PAIRS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fault_i,
  input  logic [PAIRS-1:0] pair_en_i,
  input  logic [PAIRS-1:0] combine_i,
  input  logic [NCH-1:0]   safe_i,
  input  logic [NCH-1:0]   ch_i,
  output logic [NCH-1:0]   ch_o
);
  logic [NCH-1:0] ch_d;
  logic [NCH-1:0] ch_q;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    logic force_p;
    assign force_p       = fault_i & pair_en_i[p] & combine_i[p];
    assign ch_d[2*p +: 2] = force_p ? safe_i[2*p +: 2] : ch_i[2*p +: 2];
  end

  always_ff @(posedge clk) begin
    if (rst) ch_q <= '0;
    else     ch_q <= ch_d;
  end

  assign ch_o = ch_q;
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
  import pfg_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int PAIRS  = 4,
  parameter int DW     = 16,
  parameter int FVAL_W = 4,
  parameter int CNT_W  = 5,
  localparam int NCH   = 2 * PAIRS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_IN-1:0]   fault_pin_i,
  input  logic [NCH-1:0]    ch_i,
  output logic [NCH-1:0]    ch_o,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              fault_any_o,
  output logic              fault_level_o,
  output logic              irq_o
);
  ctrl_t           ctrl_q;
  logic [N_IN-1:0] in_en_q, pol_q, fen_q;
  logic [PAIRS-1:0] pair_en_q, comb_q;
  logic [NCH-1:0]  safe_q;
  logic [N_IN-1:0] cond, rise, set, flags;
  logic            ctl_en, fault_any, level_q, irq_q;
  logic            wr_ctrl, wr_incfg, wr_pair, wr_stat, rd_stat;
  logic [DW-1:0]   rdata_q;

  assign wr_ctrl  = reg_wr_i && reg_addr_i == ADDR_CTRL;
  assign wr_incfg = reg_wr_i && reg_addr_i == ADDR_INCFG;
  assign wr_stat  = reg_wr_i && reg_addr_i == ADDR_STATUS;
  assign wr_pair  = reg_wr_i && reg_addr_i == ADDR_PAIR;
  assign rd_stat  = reg_rd_i && reg_addr_i == ADDR_STATUS;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      in_en_q   <= '0;
      pol_q     <= '0;
      fen_q     <= '0;
      pair_en_q <= '0;
      comb_q    <= '0;
      safe_q    <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.mode   <= reg_wdata_i[1:0];
        ctrl_q.irq_en <= reg_wdata_i[2];
        ctrl_q.fval   <= reg_wdata_i[4 +: FVAL_W];
      end
      if (wr_incfg) begin
        in_en_q <= reg_wdata_i[0 +: N_IN];
        pol_q   <= reg_wdata_i[N_IN +: N_IN];
        fen_q   <= reg_wdata_i[2*N_IN +: N_IN];
      end
      if (wr_pair) begin
        pair_en_q <= reg_wdata_i[0 +: PAIRS];
        comb_q    <= reg_wdata_i[PAIRS +: PAIRS];
        safe_q    <= reg_wdata_i[2*PAIRS +: NCH];
      end
    end
  end

  assign ctl_en = ctrl_q.mode != 2'b00;

  for (genvar n = 0; n < N_IN; n++) begin : g_in
    pfg_input_cond #(.FVAL_W(FVAL_W), .CNT_W(CNT_W)) cond_i (
      .clk      (clk),
      .rst      (rst),
      .pin_i    (fault_pin_i[n]),
      .pol_i    (pol_q[n]),
      .filt_en_i(fen_q[n]),
      .fval_i   (ctrl_q.fval),
      .cond_o   (cond[n]),
      .rise_o   (rise[n])
    );
  end

  assign set = rise & in_en_q & {N_IN{ctl_en}};

  pfg_flag_bank #(.N(N_IN)) flags_i (
    .clk      (clk),
    .rst      (rst),
    .set_i    (set),
    .rd_hit_i (rd_stat),
    .wr_hit_i (wr_stat),
    .wr_bits_i(reg_wdata_i[N_IN-1:0]),
    .flags_o  (flags)
  );

  assign fault_any = |flags;

  pfg_pair_override #(.PAIRS(PAIRS)) ovr_i (
    .clk      (clk),
    .rst      (rst),
    .fault_i  (ctl_en & fault_any),
    .pair_en_i(pair_en_q),
    .combine_i(comb_q),
    .safe_i   (safe_q),
    .ch_i     (ch_i),
    .ch_o     (ch_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= 1'b0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      level_q <= |cond;
      irq_q   <= fault_any & ctrl_q.irq_en;
      if (reg_rd_i) begin
        unique case (reg_addr_i)
          ADDR_CTRL:   rdata_q <= DW'({ctrl_q.fval, 1'b0, ctrl_q.irq_en, ctrl_q.mode});
          ADDR_INCFG:  rdata_q <= DW'({fen_q, pol_q, in_en_q});
          ADDR_STATUS: rdata_q <= DW'({level_q, fault_any, flags});
          default:     rdata_q <= DW'({safe_q, comb_q, pair_en_q});
        endcase
      end
    end
  end

  assign reg_rdata_o   = rdata_q;
  assign fault_any_o   = fault_any;
  assign fault_level_o = level_q;
  assign irq_o         = irq_q;

  AST_NO_SET_OFF: assert property (@(posedge clk) disable iff (rst)
    !ctl_en |=> ((flags & ~$past(flags)) == '0)); // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q.irq_en |=> !irq_o); // R10
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    !fault_any |=> (ch_o == $past(ch_i))); // R9
endmodule

// File: tb/pwm_fault_guard_tb_top.sv
module pwm_fault_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  pins = 4'h0;
  logic [7:0]  ch_in = 8'h00;
  logic [7:0]  ch_out;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'h0, rdata;
  logic        any_o, lvl_o, irq;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pwm_fault_guard dut_i (
    .clk(clk), .rst(rst), .fault_pin_i(pins), .ch_i(ch_in), .ch_o(ch_out),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .fault_any_o(any_o), .fault_level_o(lvl_o), .irq_o(irq)
  );

  // {enable, polarity, pins, expected flags, expected level}
  localparam logic [16:0] VEC [8] = '{
    {4'hF, 4'h0, 4'h1, 4'h1, 1'b1},
    {4'hF, 4'h0, 4'hA, 4'hA, 1'b1},
    {4'h5, 4'h0, 4'hF, 4'h5, 1'b1},
    {4'hF, 4'hF, 4'h0, 4'hF, 1'b1},
    {4'hF, 4'hF, 4'hF, 4'h0, 1'b0},
    {4'h0, 4'h0, 4'hF, 4'h0, 1'b1},
    {4'h3, 4'hC, 4'hC, 4'h0, 1'b0},
    {4'hF, 4'h3, 4'h1, 4'h2, 1'b1}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
    rd = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic clear_all();
    logic [15:0] s;
    reg_read(2'd2, s);
    reg_write(2'd2, 16'h0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] s;
    clks(3);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 flags", {13'h0, any_o, lvl_o, irq}, 16'h0);
    check("R11 ch_o", {8'h0, ch_out}, 16'h0);
    reg_read(2'd0, s); check("R11 ctrl", s, 16'h0);
    reg_read(2'd2, s); check("R11 status", s, 16'h0);
    // R12 readback
    reg_write(2'd1, 16'h0A5F);
    reg_read(2'd1, s); check("R12 incfg readback", s, 16'h0A5F);
    reg_write(2'd1, 16'h0000);

    // R2 R5 R6 vector table
    reg_write(2'd0, 16'h0001);
    for (int v = 0; v < 8; v++) begin
      reg_write(2'd1, {8'h00, VEC[v][12:9], VEC[v][16:13]});
      pins = VEC[v][12:9];
      clks(6);
      clear_all();
      pins = VEC[v][8:5];
      clks(6);
      reg_read(2'd2, s);
      check("R5 R2 flags", {12'h0, s[3:0]}, {12'h0, VEC[v][4:1]});
      check("R6 level", {15'h0, s[5]}, {15'h0, VEC[v][0]});
      check("R6 aggregate", {15'h0, s[4]}, {15'h0, |VEC[v][4:1]});
    end
    pins = 4'h0;
    reg_write(2'd1, 16'h000F);
    clks(6);
    clear_all();

    // R1 latency
    pins[0] = 1'b1;
    clks(2); check("R1 not yet", {15'h0, any_o}, 16'h0);
    clks(1); check("R1 set at k+2", {15'h0, any_o}, 16'h1);
    pins[0] = 1'b0; clks(6);

    // R7 clear protocol
    reg_write(2'd2, 16'h0);
    check("R7 write0 unread", {15'h0, any_o}, 16'h1);
    reg_read(2'd2, s);
    reg_write(2'd2, 16'h000F);
    check("R7 write1", {15'h0, any_o}, 16'h1);
    reg_write(2'd2, 16'h0);
    check("R7 cleared", {15'h0, any_o}, 16'h0);

    // R8 set wins over clear
    pins[0] = 1'b1; clks(6);
    reg_read(2'd2, s);
    pins[0] = 1'b0; clks(6);
    pins[0] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    reg_write(2'd2, 16'h0);
    check("R8 set wins", {15'h0, any_o}, 16'h1);
    pins[0] = 1'b0; clks(6);
    clear_all();
    check("R8 later clear", {15'h0, any_o}, 16'h0);

    // R5 mode zero blocks flags, level still shown (R6)
    reg_write(2'd0, 16'h0000);
    pins = 4'h2; clks(6);
    check("R5 mode off", {15'h0, any_o}, 16'h0);
    check("R6 level mode off", {15'h0, lvl_o}, 16'h1);
    pins = 4'h0; clks(6);

    // R4 filter length 4 on input 0
    reg_write(2'd0, 16'h0041);
    reg_write(2'd1, 16'h010F);
    pins[0] = 1'b1; clks(2); pins[0] = 1'b0; clks(10);
    check("R4 short pulse dropped", {15'h0, any_o}, 16'h0);
    pins[0] = 1'b1; clks(3); pins[0] = 1'b0; clks(10);
    check("R4 3-clk pulse dropped", {15'h0, any_o}, 16'h0);
    pins[0] = 1'b1; clks(8);
    check("R4 long pulse passes", {15'h0, any_o}, 16'h1);
    pins[0] = 1'b0; clks(10); clear_all();

    // R3 bypass: filter length zero, then filter enable off
    reg_write(2'd0, 16'h0001);
    pins[0] = 1'b1; clks(1); pins[0] = 1'b0; clks(6);
    check("R3 fval zero bypass", {15'h0, any_o}, 16'h1);
    clear_all();
    reg_write(2'd0, 16'h0041);
    reg_write(2'd1, 16'h000F);
    pins[0] = 1'b1; clks(1); pins[0] = 1'b0; clks(6);
    check("R3 fen off bypass", {15'h0, any_o}, 16'h1);

    // R9 override, flag still set
    ch_in = 8'h55;
    reg_write(2'd3, 16'h0211);
    clks(1);
    check("R9 pair0 forced", {8'h0, ch_out}, 16'h0056);
    reg_write(2'd3, 16'h0201);
    clks(1);
    check("R9 no combine", {8'h0, ch_out}, 16'h0055);
    reg_write(2'd3, 16'h0211);
    reg_write(2'd0, 16'h0040);
    clks(1);
    check("R9 mode off", {8'h0, ch_out}, 16'h0055);

    // R10 interrupt
    reg_write(2'd0, 16'h0005);
    clks(1);
    check("R10 irq on", {15'h0, irq}, 16'h1);
    check("R9 forced again", {8'h0, ch_out}, 16'h0056);
    reg_write(2'd0, 16'h0001);
    clks(1);
    check("R10 irq en off", {15'h0, irq}, 16'h0);
    reg_write(2'd0, 16'h0005);
    clks(1);
    check("R10 irq back", {15'h0, irq}, 16'h1);
    clear_all();
    clks(1);
    check("R10 irq after clear", {15'h0, irq}, 16'h0);
    check("R9 released", {8'h0, ch_out}, 16'h0055);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule